// File: doc/BRIEF.md
# Speculative Poison-Tagged Register File

This block holds the general-purpose registers and the condition codes of one operation slot. Each entry carries one extra poison bit that marks a deferred fault. An operation is issued with up to three sources: two registers and one condition code. It also names up to two destinations: one register and one condition code. One clock later the block returns the source values and their poison bits to the arithmetic unit. In that same cycle the unit hands back a result, a condition-code result and an error indication, and the block writes them at the end of the cycle.

A speculative operation never traps. If it faults, or if it reads a poisoned source, its destinations are written with the poison bit set. A nonspeculative operation that reads a poisoned source raises a registered trap. The trap names the offending source, and the operation's destinations are left untouched. A nonspeculative operation that does not trap always writes clean results. This lets a scheduler hoist operations above branches and report a fault only when the faulting value is actually consumed on the path that is taken.

Top module: `spec_poison_rf`

## Requirements
- R1: Asserting `rst` for one clock makes every register and every condition code read back as zero with a clear poison bit, and clears `trap_valid`.
- R2: Operand outputs appear in the cycle after `op_valid` and hold while `op_valid` is low. A read issued in the same cycle that a write to that register completes returns the value from before the write.
- R3: A nonspeculative operation that does not trap writes its destinations with the poison bit clear, even when `res_err` is high.
- R4: A speculative operation with `res_err` high writes its register and condition-code destinations with the poison bit set.
- R5: A speculative operation whose used sources include a poisoned register or condition code writes its destinations poisoned.
- R6: A speculative operation with clean used sources and `res_err` low writes its destinations with the poison bit clear.
- R7: A nonspeculative operation with a poisoned used source raises `trap_valid` for one cycle, in the cycle after issue. `trap_is_cc` is 1 when the offending source is a condition code. `trap_idx` holds the register index, or the condition-code index zero-extended.
- R8: An operation that traps writes neither its register destination nor its condition-code destination.
- R9: When several used sources are poisoned, the trap names the first source in this order: register source 1, then register source 2, then the condition-code source.
- R10: A source whose use bit is low neither poisons the result nor causes a trap, whatever its index points at.
- R11: A speculative operation never raises `trap_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is issued this cycle |
| op_spec | input | 1 | The issued operation is speculative |
| src1_use | input | 1 | Register source 1 is read by the operation |
| src1_idx | input | 6 | Register source 1 index |
| src2_use | input | 1 | Register source 2 is read by the operation |
| src2_idx | input | 6 | Register source 2 index |
| srccc_use | input | 1 | Condition-code source is read by the operation |
| srccc_idx | input | 3 | Condition-code source index |
| dst_use | input | 1 | The operation writes a register |
| dst_idx | input | 6 | Register destination index |
| dstcc_use | input | 1 | The operation writes a condition code |
| dstcc_idx | input | 3 | Condition-code destination index |
| res_data | input | 32 | Register result, valid in the cycle after issue |
| res_cc | input | 1 | Condition-code result, valid in the cycle after issue |
| res_err | input | 1 | The arithmetic unit reports a fault for this result |
| opnd1_data | output | 32 | Register source 1 value |
| opnd1_tag | output | 1 | Register source 1 poison bit |
| opnd2_data | output | 32 | Register source 2 value |
| opnd2_tag | output | 1 | Register source 2 poison bit |
| opndcc_val | output | 1 | Condition-code source value |
| opndcc_tag | output | 1 | Condition-code source poison bit |
| trap_valid | output | 1 | Deferred fault consumed by a nonspeculative operation |
| trap_is_cc | output | 1 | The offending source is a condition code |
| trap_idx | output | 6 | Index of the offending source |

## Verification
A poison bit that is lost or set by mistake inside the file stays hidden until that entry is read again. It then shows on the operand tag one cycle after the read is issued. If the reader is nonspeculative, the fault also shows on `trap_valid` in that same cycle. A trapping operation that wrongly writes its destination is caught by a later read of that destination, which returns the new value instead of the untouched one. Errors in the live-entry state after reset, or in the read-before-write ordering, show as wrong operand values in the cycle after the read is issued.

// File: rtl/spec_rf_pkg.sv
package spec_rf_pkg;

  // Which source, if any, carried the first poison bit found.
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_A    = 2'd1,
    SRC_B    = 2'd2,
    SRC_CC   = 2'd3
  } fault_src_e;

endpackage

// File: rtl/spec_rf_gpr.sv
// Register bank: two registered read ports, one write port, read-first.
// Data array has no reset so it maps to block RAM; a live vector masks
// never-written entries to zero after reset.
module spec_rf_gpr #(
  parameter int NUM_REGS = 64,
  parameter int DATA_W   = 32,
  localparam int IW      = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [IW-1:0]     ra,
  input  logic [IW-1:0]     rb,
  output logic              tag_a,
  output logic              tag_b,
  output logic [DATA_W-1:0] qa,
  output logic [DATA_W-1:0] qb,
  input  logic              we,
  input  logic [IW-1:0]     wa,
  input  logic [DATA_W-1:0] wd,
  input  logic              wtag
);

  logic [DATA_W-1:0] mem [NUM_REGS];
  logic [NUM_REGS-1:0] live;
  logic [NUM_REGS-1:0] tags;
  logic [DATA_W-1:0] qa_raw, qb_raw;
  logic live_a, live_b;

  always_ff @(posedge clk) begin
    if (rd_en) begin
      qa_raw <= mem[ra];
      qb_raw <= mem[rb];
    end
    if (we) mem[wa] <= wd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live   <= '0;
      tags   <= '0;
      live_a <= 1'b0;
      live_b <= 1'b0;
    end else begin
      if (rd_en) begin
        live_a <= live[ra];
        live_b <= live[rb];
      end
      if (we) begin
        live[wa] <= 1'b1;
        tags[wa] <= wtag;
      end
    end
  end

  assign tag_a = tags[ra] & live[ra];
  assign tag_b = tags[rb] & live[rb];
  assign qa    = qa_raw & {DATA_W{live_a}};
  assign qb    = qb_raw & {DATA_W{live_b}};

endmodule

// File: rtl/spec_rf_ccfile.sv
// Condition-code bank: value and poison bit per code, one read, one write.
module spec_rf_ccfile #(
  parameter int NUM_CC = 8,
  localparam int CW    = $clog2(NUM_CC)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] ridx,
  output logic          rval,
  output logic          rtag,
  input  logic          we,
  input  logic [CW-1:0] widx,
  input  logic          wval,
  input  logic          wtag
);

  logic [NUM_CC-1:0] vals;
  logic [NUM_CC-1:0] tags;

  always_ff @(posedge clk) begin
    if (rst) begin
      vals <= '0;
      tags <= '0;
    end else if (we) begin
      vals[widx] <= wval;
      tags[widx] <= wtag;
    end
  end

  assign rval = vals[ridx];
  assign rtag = tags[ridx];

endmodule

// File: rtl/spec_rf_guard.sv
// Combines source poison bits and picks the offending source by priority.
module spec_rf_guard
  import spec_rf_pkg::*;
#(
  parameter int IW = 6,
  parameter int CW = 3
) (
  input  logic          spec,
  input  logic          use_a,
  input  logic          tag_a,
  input  logic [IW-1:0] idx_a,
  input  logic          use_b,
  input  logic          tag_b,
  input  logic [IW-1:0] idx_b,
  input  logic          use_c,
  input  logic          tag_c,
  input  logic [CW-1:0] idx_c,
  output logic          poison,
  output logic          fault,
  output logic          fault_is_cc,
  output logic [IW-1:0] fault_idx
);

  fault_src_e src;

  always_comb begin
    if (use_a && tag_a)      src = SRC_A;
    else if (use_b && tag_b) src = SRC_B;
    else if (use_c && tag_c) src = SRC_CC;
    else                     src = SRC_NONE;
  end

  always_comb begin
    unique case (src)
      SRC_A:   fault_idx = idx_a;
      SRC_B:   fault_idx = idx_b;
      SRC_CC:  fault_idx = {{(IW-CW){1'b0}}, idx_c};
      default: fault_idx = '0;
    endcase
  end

  assign poison      = (src != SRC_NONE);
  assign fault       = poison && !spec;
  assign fault_is_cc = (src == SRC_CC);

endmodule

// File: rtl/spec_poison_rf.sv
// Top: issue stage reads sources and checks poison; the following cycle
// writes the unit's result with the propagated poison bit.
module spec_poison_rf #(
  parameter int NUM_REGS = 64,
  parameter int DATA_W   = 32,
  parameter int NUM_CC   = 8,
  localparam int IW      = $clog2(NUM_REGS),
  localparam int CW      = $clog2(NUM_CC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic              op_spec,
  input  logic              src1_use,
  input  logic [IW-1:0]     src1_idx,
  input  logic              src2_use,
  input  logic [IW-1:0]     src2_idx,
  input  logic              srccc_use,
  input  logic [CW-1:0]     srccc_idx,
  input  logic              dst_use,
  input  logic [IW-1:0]     dst_idx,
  input  logic              dstcc_use,
  input  logic [CW-1:0]     dstcc_idx,
  input  logic [DATA_W-1:0] res_data,
  input  logic              res_cc,
  input  logic              res_err,
  output logic [DATA_W-1:0] opnd1_data,
  output logic              opnd1_tag,
  output logic [DATA_W-1:0] opnd2_data,
  output logic              opnd2_tag,
  output logic              opndcc_val,
  output logic              opndcc_tag,
  output logic              trap_valid,
  output logic              trap_is_cc,
  output logic [IW-1:0]     trap_idx
);

  logic          tag_a, tag_b, cc_val, cc_tag;
  logic          poison, fault, fault_is_cc;
  logic [IW-1:0] fault_idx;

  // Write-stage state captured at issue.
  logic          wr_gpr, wr_cc, wr_spec, wr_poison;
  logic [IW-1:0] wr_idx;
  logic [CW-1:0] wr_ccidx;
  logic          wr_tag;

  assign wr_tag = wr_spec & (wr_poison | res_err);

  spec_rf_gpr #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_gpr (
    .clk  (clk),
    .rst  (rst),
    .rd_en(op_valid),
    .ra   (src1_idx),
    .rb   (src2_idx),
    .tag_a(tag_a),
    .tag_b(tag_b),
    .qa   (opnd1_data),
    .qb   (opnd2_data),
    .we   (wr_gpr),
    .wa   (wr_idx),
    .wd   (res_data),
    .wtag (wr_tag)
  );

  spec_rf_ccfile #(.NUM_CC(NUM_CC)) u_cc (
    .clk (clk),
    .rst (rst),
    .ridx(srccc_idx),
    .rval(cc_val),
    .rtag(cc_tag),
    .we  (wr_cc),
    .widx(wr_ccidx),
    .wval(res_cc),
    .wtag(wr_tag)
  );

  spec_rf_guard #(.IW(IW), .CW(CW)) u_guard (
    .spec       (op_spec),
    .use_a      (src1_use),
    .tag_a      (tag_a),
    .idx_a      (src1_idx),
    .use_b      (src2_use),
    .tag_b      (tag_b),
    .idx_b      (src2_idx),
    .use_c      (srccc_use),
    .tag_c      (cc_tag),
    .idx_c      (srccc_idx),
    .poison     (poison),
    .fault      (fault),
    .fault_is_cc(fault_is_cc),
    .fault_idx  (fault_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_gpr     <= 1'b0;
      wr_cc      <= 1'b0;
      wr_spec    <= 1'b0;
      wr_poison  <= 1'b0;
      wr_idx     <= '0;
      wr_ccidx   <= '0;
      trap_valid <= 1'b0;
      trap_is_cc <= 1'b0;
      trap_idx   <= '0;
      opnd1_tag  <= 1'b0;
      opnd2_tag  <= 1'b0;
      opndcc_val <= 1'b0;
      opndcc_tag <= 1'b0;
    end else begin
      wr_gpr     <= op_valid && dst_use && !fault;
      wr_cc      <= op_valid && dstcc_use && !fault;
      wr_spec    <= op_spec;
      wr_poison  <= poison;
      wr_idx     <= dst_idx;
      wr_ccidx   <= dstcc_idx;
      trap_valid <= op_valid && fault;
      trap_is_cc <= fault_is_cc;
      trap_idx   <= fault_idx;
      if (op_valid) begin
        opnd1_tag  <= tag_a;
        opnd2_tag  <= tag_b;
        opndcc_val <= cc_val;
        opndcc_tag <= cc_tag;
      end
    end
  end

endmodule

// File: rtl/spec_poison_rf_chk.sv
module spec_poison_rf_chk #(
  parameter int NUM_REGS = 64,
  parameter int DATA_W   = 32,
  parameter int NUM_CC   = 8,
  localparam int IW      = $clog2(NUM_REGS),
  localparam int CW      = $clog2(NUM_CC)
) (
  input logic              clk,
  input logic              rst,
  input logic              op_valid,
  input logic              op_spec,
  input logic              src1_use,
  input logic [IW-1:0]     src1_idx,
  input logic              src2_use,
  input logic              srccc_use,
  input logic [DATA_W-1:0] opnd1_data,
  input logic              opnd1_tag,
  input logic [DATA_W-1:0] opnd2_data,
  input logic              opnd2_tag,
  input logic              opndcc_tag,
  input logic              trap_valid,
  input logic              trap_is_cc,
  input logic [IW-1:0]     trap_idx
);

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !trap_valid);

  assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> ($stable(opnd1_data) && $stable(opnd2_data)));

  assert_trap_from_tags_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (trap_valid == ($past(op_valid && !op_spec) &&
      (($past(src1_use) && opnd1_tag) || ($past(src2_use) && opnd2_tag) ||
       ($past(srccc_use) && opndcc_tag)))));

  assert_trap_priority_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && trap_valid && $past(src1_use) && opnd1_tag) |->
      (!trap_is_cc && trap_idx == $past(src1_idx)));

  assert_spec_never_traps_R11: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_spec) |=> !trap_valid);

endmodule

bind spec_poison_rf spec_poison_rf_chk #(
  .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .NUM_CC(NUM_CC)
) u_chk (.*);

// File: tb/spec_poison_rf_test.sv
module spec_poison_rf_test;

  localparam int CLK_PERIOD = 10;
  localparam int NR = 64;
  localparam int NC = 8;

  typedef struct packed {
    logic        spec;
    logic        s1u;
    logic [5:0]  s1;
    logic        s2u;
    logic [5:0]  s2;
    logic        cu;
    logic [2:0]  ci;
    logic        du;
    logic [5:0]  d;
    logic        dcu;
    logic [2:0]  dc;
    logic [31:0] data;
    logic        ccv;
    logic        err;
    logic [3:0]  rq;
  } vec_t;

  // Fields: spec,s1u,s1,s2u,s2,cu,ci,du,d,dcu,dc,data,ccv,err,req
  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,6'd0, 1'b0,6'd0, 1'b0,3'd0,1'b1,6'd5, 1'b1,3'd2,32'h1111_1111,1'b1,1'b0,4'd3},  // R3
    '{1'b1,1'b1,6'd5, 1'b0,6'd0, 1'b0,3'd0,1'b1,6'd6, 1'b1,3'd3,32'hDEAD_0006,1'b1,1'b1,4'd4},  // R4
    '{1'b1,1'b1,6'd6, 1'b0,6'd0, 1'b0,3'd0,1'b1,6'd7, 1'b0,3'd0,32'h0000_0077,1'b0,1'b0,4'd5},  // R5
    '{1'b1,1'b1,6'd5, 1'b1,6'd0, 1'b0,3'd0,1'b1,6'd8, 1'b1,3'd4,32'h0000_0088,1'b0,1'b0,4'd6},  // R6
    '{1'b0,1'b1,6'd5, 1'b1,6'd7, 1'b0,3'd0,1'b1,6'd9, 1'b0,3'd0,32'h0000_0099,1'b0,1'b0,4'd7},  // R7
    '{1'b0,1'b1,6'd9, 1'b0,6'd0, 1'b0,3'd0,1'b1,6'd10,1'b0,3'd0,32'h0000_000A,1'b0,1'b0,4'd8},  // R8
    '{1'b0,1'b0,6'd0, 1'b0,6'd0, 1'b1,3'd3,1'b1,6'd13,1'b0,3'd0,32'h0000_000D,1'b0,1'b0,4'd7},  // R7 cc
    '{1'b0,1'b1,6'd6, 1'b1,6'd7, 1'b1,3'd3,1'b0,6'd0, 1'b0,3'd0,32'h0,        1'b0,1'b0,4'd9},  // R9
    '{1'b0,1'b0,6'd7, 1'b1,6'd8, 1'b0,3'd3,1'b1,6'd11,1'b0,3'd0,32'h0000_000B,1'b0,1'b0,4'd10}, // R10
    '{1'b0,1'b1,6'd5, 1'b0,6'd0, 1'b0,3'd0,1'b1,6'd6, 1'b1,3'd3,32'h0000_6666,1'b0,1'b1,4'd3},  // R3
    '{1'b1,1'b1,6'd7, 1'b0,6'd0, 1'b1,3'd3,1'b1,6'd12,1'b1,3'd5,32'h0000_0012,1'b1,1'b0,4'd11}, // R11
    '{1'b0,1'b1,6'd6, 1'b0,6'd0, 1'b1,3'd3,1'b0,6'd0, 1'b0,3'd0,32'h0,        1'b0,1'b0,4'd3},  // R3
    '{1'b1,1'b1,6'd11,1'b0,6'd0, 1'b0,3'd0,1'b1,6'd63,1'b0,3'd0,32'hFFFF_0000,1'b0,1'b0,4'd6},  // R6
    '{1'b0,1'b1,6'd63,1'b1,6'd12,1'b1,3'd5,1'b0,6'd0, 1'b0,3'd0,32'h0,        1'b0,1'b0,4'd9},  // R9
    '{1'b0,1'b1,6'd63,1'b0,6'd0, 1'b1,3'd4,1'b0,6'd0, 1'b0,3'd0,32'h0,        1'b0,1'b0,4'd6}   // R6
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0, op_spec = 1'b0;
  logic        src1_use = 1'b0, src2_use = 1'b0, srccc_use = 1'b0;
  logic [5:0]  src1_idx = '0, src2_idx = '0, dst_idx = '0;
  logic [2:0]  srccc_idx = '0, dstcc_idx = '0;
  logic        dst_use = 1'b0, dstcc_use = 1'b0;
  logic [31:0] res_data = '0;
  logic        res_cc = 1'b0, res_err = 1'b0;
  logic [31:0] opnd1_data, opnd2_data;
  logic        opnd1_tag, opnd2_tag, opndcc_val, opndcc_tag;
  logic        trap_valid, trap_is_cc;
  logic [5:0]  trap_idx;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [31:0] m_data [NR];
  logic        m_tag  [NR];
  logic        m_cc   [NC];
  logic        m_cctag[NC];

  always #(CLK_PERIOD/2) clk = ~clk;

  spec_poison_rf uut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_spec(op_spec),
    .src1_use(src1_use), .src1_idx(src1_idx), .src2_use(src2_use), .src2_idx(src2_idx),
    .srccc_use(srccc_use), .srccc_idx(srccc_idx), .dst_use(dst_use), .dst_idx(dst_idx),
    .dstcc_use(dstcc_use), .dstcc_idx(dstcc_idx), .res_data(res_data), .res_cc(res_cc),
    .res_err(res_err), .opnd1_data(opnd1_data), .opnd1_tag(opnd1_tag),
    .opnd2_data(opnd2_data), .opnd2_tag(opnd2_tag), .opndcc_val(opndcc_val),
    .opndcc_tag(opndcc_tag), .trap_valid(trap_valid), .trap_is_cc(trap_is_cc),
    .trap_idx(trap_idx)
  );

  task automatic check(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < NR; i++) begin m_data[i] = '0; m_tag[i] = 1'b0; end
    for (int i = 0; i < NC; i++) begin m_cc[i] = 1'b0; m_cctag[i] = 1'b0; end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; op_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_clear();
  endtask

  function automatic vec_t mk_read(input logic [5:0] a, input logic [5:0] b,
                                   input logic [2:0] c, input logic [3:0] rq);
    vec_t v = '0;
    v.s1u = 1'b1; v.s1 = a; v.s2u = 1'b1; v.s2 = b; v.cu = 1'b1; v.ci = c; v.rq = rq;
    return v;
  endfunction

  // Issue one operation, supply its result, check the operands and trap.
  task automatic issue(input vec_t v);
    string rq;
    logic p1, p2, pc, exp_trap, exp_cc, wtag;
    logic [5:0] exp_idx;
    rq = $sformatf("R%0d", v.rq);
    @(negedge clk);
    op_valid = 1'b1; op_spec = v.spec;
    src1_use = v.s1u; src1_idx = v.s1; src2_use = v.s2u; src2_idx = v.s2;
    srccc_use = v.cu; srccc_idx = v.ci; dst_use = v.du; dst_idx = v.d;
    dstcc_use = v.dcu; dstcc_idx = v.dc;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0; res_data = v.data; res_cc = v.ccv; res_err = v.err;
    p1 = v.s1u && m_tag[v.s1];
    p2 = v.s2u && m_tag[v.s2];
    pc = v.cu && m_cctag[v.ci];
    exp_trap = !v.spec && (p1 || p2 || pc);
    exp_cc   = !p1 && !p2 && pc;
    exp_idx  = p1 ? v.s1 : (p2 ? v.s2 : {3'b000, v.ci});
    if (v.s1u) begin
      check(rq, "opnd1_data", opnd1_data, m_data[v.s1]);
      check(rq, "opnd1_tag", {31'd0, opnd1_tag}, {31'd0, m_tag[v.s1]});
    end
    if (v.s2u) begin
      check(rq, "opnd2_data", opnd2_data, m_data[v.s2]);
      check(rq, "opnd2_tag", {31'd0, opnd2_tag}, {31'd0, m_tag[v.s2]});
    end
    if (v.cu) begin
      check(rq, "opndcc_val", {31'd0, opndcc_val}, {31'd0, m_cc[v.ci]});
      check(rq, "opndcc_tag", {31'd0, opndcc_tag}, {31'd0, m_cctag[v.ci]});
    end
    check(rq, "trap_valid", {31'd0, trap_valid}, {31'd0, exp_trap});
    if (exp_trap) begin
      check(rq, "trap_is_cc", {31'd0, trap_is_cc}, {31'd0, exp_cc});
      check(rq, "trap_idx", {26'd0, trap_idx}, {26'd0, exp_idx});
    end
    wtag = v.spec && (p1 || p2 || pc || v.err);
    if (!exp_trap) begin
      if (v.du)  begin m_data[v.d] = v.data; m_tag[v.d] = wtag; end
      if (v.dcu) begin m_cc[v.dc] = v.ccv; m_cctag[v.dc] = wtag; end
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: state straight out of reset
    issue(mk_read(6'd0, 6'd63, 3'd7, 4'd1));

    for (int i = 0; i < NV; i++) issue(VECS[i]);

    // R1: reset in mid-run wipes written and poisoned entries
    do_reset();
    issue(mk_read(6'd5, 6'd6, 3'd5, 4'd1));
    issue(mk_read(6'd12, 6'd63, 3'd2, 4'd1));

    // R2: read in the cycle its write completes sees the old value
    @(negedge clk);
    op_valid = 1'b1; op_spec = 1'b0;
    src1_use = 1'b0; src2_use = 1'b0; srccc_use = 1'b0;
    dst_use = 1'b1; dst_idx = 6'd20; dstcc_use = 1'b0;
    @(negedge clk);
    res_data = 32'h2020_2020; res_err = 1'b0;
    src1_use = 1'b1; src1_idx = 6'd20; dst_use = 1'b0;
    @(negedge clk);
    op_valid = 1'b0;
    check("R2", "read-first opnd1_data", opnd1_data, 32'h0);
    m_data[20] = 32'h2020_2020;
    issue(mk_read(6'd20, 6'd20, 3'd0, 4'd2));

    @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule